// File: doc/BRIEF.md
# IO Page Translator with Fault Capture

The block turns a device DMA address into a physical address with one lookup in a page table held in memory. Each request carries an IO address and a read/write flag. The block works out where the matching table entry lives from a table base and the part of the IO address that falls inside the current IO window. It fetches that 32-bit entry over a req/ack memory read port and checks the entry's valid and write-permission bits.

When the checks pass, the block finishes the request with the translated physical address. When they fail, it drops the access. It then loads a fixed error status word into the status register and puts the page-aligned faulting IO address into the error address register, where software can read them. Each request ends with a one-cycle done pulse that carries an error flag. The block handles one request at a time.

Top module: `iopt_xlate`

## Requirements
- R1: After reset the block shows the following values. req_ready_o is 1. mem_req_o, done_o and done_err_o are 0. err_status_o and err_addr_o are 0.
- R2: The entry address is (base_i << 4) + (((req_addr_i AND (2^W - 1)) >> 12) << 2). It is 36 bits wide. The window exponent W is 24 + range_sel_i, which gives 16 MiB when range_sel_i is 0 and 2 GiB when it is 7. base_i and range_sel_i are sampled in the cycle the request is accepted.
- R3: A request is accepted when req_valid_i and req_ready_o are both high. From the next cycle, mem_req_o stays high and mem_addr_o stays stable until the cycle in which mem_ack_i is high. req_ready_o is low while mem_req_o is high.
- R4: An entry with bit 1 (valid) clear makes the request fault.
- R5: A write whose entry has bit 2 (write permission) clear faults. A read does not depend on bit 2.
- R6: A fault loads err_status_o with 0xC0820000 for a write and 0xC0860000 for a read. The set bits are 31, 30, 17, the field 23:20 equal to 8, and bit 18 for a read.
- R7: A fault loads err_addr_o with the faulting IO address with bits 11:0 cleared.
- R8: On success, xlat_addr_o is {entry[31:8], req_addr_i[11:0]} and done_err_o is 0. Entry bits 7:0 other than bits 1 and 2 have no effect, and err_status_o and err_addr_o keep their values.
- R9: Every new fault overwrites both fault registers.
- R10: IO address bits at or above the window exponent do not change the entry address.
- R11: done_o is high for exactly one cycle, the cycle after the ack edge, once per request. done_err_o is 1 there exactly when the request faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle and able to accept a request |
| req_addr_i | input | 32 | IO address |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| base_i | input | 32 | Page table base, in units of 16 bytes |
| range_sel_i | input | 3 | IO window size select, 2^(24+n) bytes |
| mem_req_o | output | 1 | Entry fetch request |
| mem_addr_o | output | 36 | Entry byte address |
| mem_ack_i | input | 1 | Fetch complete, entry valid on mem_rdata_i |
| mem_rdata_i | input | 32 | Fetched page table entry |
| done_o | output | 1 | One-cycle completion pulse |
| done_err_o | output | 1 | The completed request faulted |
| xlat_addr_o | output | 36 | Translated physical address, zero on fault |
| err_status_o | output | 32 | Error status register |
| err_addr_o | output | 32 | Error address register |

## Verification
A wrong index or window mask in the address path shows on mem_addr_o as soon as the fetch starts, one cycle after the request is accepted. A wrong permission decision shows on done_err_o and xlat_addr_o in the cycle after the ack. A fault register that is loaded when it should not be, or not loaded when it should be, shows on err_status_o and err_addr_o in that same cycle. The sweep therefore compares every one of these outputs on every request and keeps its own model of the fault registers across requests.

// File: rtl/iopt_pkg.sv
package iopt_pkg;
  localparam int unsigned PG_SHIFT  = 12;
  localparam int unsigned PTE_W     = 32;
  localparam int unsigned PTE_V_BIT = 1;
  localparam int unsigned PTE_W_BIT = 2;
  localparam int unsigned PPN_LSB   = 8;

  typedef enum logic {ST_IDLE, ST_FETCH} iopt_state_e;

  // composite fault status word
  function automatic logic [31:0] fault_word(input logic is_read);
    logic [31:0] w;
    w        = '0;
    w[31]    = 1'b1;
    w[30]    = 1'b1;
    w[23:20] = 4'h8;
    w[18]    = is_read;
    w[17]    = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/iopt_entry_addr.sv
module iopt_entry_addr
  import iopt_pkg::*;
#(
  parameter int unsigned IOA_W   = 32,
  parameter int unsigned RSEL_W  = 3,
  parameter int unsigned MIN_WIN = 24,
  localparam int unsigned ENT_W  = IOA_W + 4
) (
  input  logic [IOA_W-1:0]  io_addr_i,
  input  logic [IOA_W-1:0]  base_i,
  input  logic [RSEL_W-1:0] range_sel_i,
  output logic [ENT_W-1:0]  entry_addr_o
);
  logic [IOA_W-1:0] win_mask;
  logic [IOA_W-1:0] page_idx;

  always_comb begin
    for (int b = 0; b < int'(IOA_W); b++)
      win_mask[b] = (b < (int'(MIN_WIN) + int'(range_sel_i)));
  end

  assign page_idx     = (io_addr_i & win_mask) >> PG_SHIFT;
  assign entry_addr_o = (ENT_W'(base_i) << 4) + (ENT_W'(page_idx) << 2);
endmodule

// File: rtl/iopt_perm_check.sv
module iopt_perm_check
  import iopt_pkg::*;
#(
  localparam int unsigned PA_W = PTE_W - PPN_LSB + PG_SHIFT
) (
  input  logic [PTE_W-1:0]    pte_i,
  input  logic                is_write_i,
  input  logic [PG_SHIFT-1:0] pg_off_i,
  output logic                fault_o,
  output logic [PA_W-1:0]     phys_o
);
  assign fault_o = !pte_i[PTE_V_BIT] || (is_write_i && !pte_i[PTE_W_BIT]);
  assign phys_o  = {pte_i[PTE_W-1:PPN_LSB], pg_off_i};
endmodule

// File: rtl/iopt_fault_regs.sv
module iopt_fault_regs
  import iopt_pkg::*;
#(
  parameter int unsigned IOA_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             is_read_i,
  input  logic [IOA_W-1:0] io_addr_i,
  output logic [31:0]      status_o,
  output logic [IOA_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o <= '0;
      addr_o   <= '0;
    end else if (load_i) begin
      status_o <= fault_word(is_read_i);
      addr_o   <= {io_addr_i[IOA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
    end
  end

  assert_status_rd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (status_o[18] == $past(is_read_i)) && status_o[31] && status_o[17]);
  assert_addr_page_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> addr_o[IOA_W-1:PG_SHIFT] == $past(io_addr_i[IOA_W-1:PG_SHIFT]));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(status_o) && $stable(addr_o));
endmodule

// File: rtl/iopt_xlate.sv
module iopt_xlate
  import iopt_pkg::*;
#(
  parameter int unsigned IOA_W   = 32,
  parameter int unsigned RSEL_W  = 3,
  parameter int unsigned MIN_WIN = 24,
  localparam int unsigned ENT_W  = IOA_W + 4,
  localparam int unsigned PA_W   = PTE_W - PPN_LSB + PG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [IOA_W-1:0]  req_addr_i,
  input  logic              req_write_i,
  input  logic [IOA_W-1:0]  base_i,
  input  logic [RSEL_W-1:0] range_sel_i,
  output logic              mem_req_o,
  output logic [ENT_W-1:0]  mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  output logic              done_o,
  output logic              done_err_o,
  output logic [PA_W-1:0]   xlat_addr_o,
  output logic [31:0]       err_status_o,
  output logic [IOA_W-1:0]  err_addr_o
);
  iopt_state_e      state_q;
  logic [IOA_W-1:0] io_q;
  logic             wr_q;
  logic [ENT_W-1:0] ent_d;
  logic             fault;
  logic [PA_W-1:0]  phys;
  logic             fault_load;

  iopt_entry_addr #(.IOA_W(IOA_W), .RSEL_W(RSEL_W), .MIN_WIN(MIN_WIN)) u_ent (
    .io_addr_i   (req_addr_i),
    .base_i      (base_i),
    .range_sel_i (range_sel_i),
    .entry_addr_o(ent_d)
  );

  iopt_perm_check u_perm (
    .pte_i     (mem_rdata_i),
    .is_write_i(wr_q),
    .pg_off_i  (io_q[PG_SHIFT-1:0]),
    .fault_o   (fault),
    .phys_o    (phys)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign mem_req_o   = (state_q == ST_FETCH);
  assign fault_load  = mem_req_o && mem_ack_i && fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      io_q        <= '0;
      wr_q        <= 1'b0;
      mem_addr_o  <= '0;
      done_o      <= 1'b0;
      done_err_o  <= 1'b0;
      xlat_addr_o <= '0;
    end else begin
      done_o     <= 1'b0;
      done_err_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid_i) begin
          io_q       <= req_addr_i;
          wr_q       <= req_write_i;
          mem_addr_o <= ent_d;
          state_q    <= ST_FETCH;
        end
        ST_FETCH: if (mem_ack_i) begin
          done_o      <= 1'b1;
          done_err_o  <= fault;
          xlat_addr_o <= fault ? '0 : phys;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  iopt_fault_regs #(.IOA_W(IOA_W)) u_fregs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (fault_load),
    .is_read_i(!wr_q),
    .io_addr_i(io_q),
    .status_o (err_status_o),
    .addr_o   (err_addr_o)
  );

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o));
  assert_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_ack_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_req_o && mem_ack_i));
  assert_err_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && done_err_o) |-> err_status_o[31] && err_status_o[30]);
  assert_ok_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !done_err_o) |-> $stable(err_status_o) && $stable(err_addr_o));
endmodule

// File: tb/sim_iopt_xlate.sv
module sim_iopt_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] base = '0;
  logic [2:0]  range_sel = '0;
  logic        mem_req;
  logic [35:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done, done_err;
  logic [35:0] xlat_addr;
  logic [31:0] err_status, err_addr;

  int compared = 0;
  int mismatched = 0;
  logic [31:0] exp_status = '0;
  logic [31:0] exp_eaddr = '0;
  logic        had_fault = 1'b0;

  always #2.5 clk = ~clk;

  iopt_xlate u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_write_i(req_write),
    .base_i(base), .range_sel_i(range_sel),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .done_o(done), .done_err_o(done_err), .xlat_addr_o(xlat_addr),
    .err_status_o(err_status), .err_addr_o(err_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_req(input logic [31:0] a, input bit wr, input logic [31:0] pte,
                         input int lat);
    logic [31:0] mask;
    logic [35:0] exp_ea;
    logic [35:0] exp_pa;
    bit          flt;
    mask   = (32'h1 << (24 + int'(range_sel))) - 32'h1;
    exp_ea = ({4'b0, base} << 4) + ({4'b0, (a & mask) >> 12} << 2);
    flt    = !pte[1] || (wr && !pte[2]);
    exp_pa = flt ? 36'h0 : {pte[31:8], a[11:0]};
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a;
    chk(mem_req === 1'b1, "R3 fetch start", 64'(mem_req), 64'h1);
    chk(mem_addr === exp_ea, "R2/R10 entry addr", 64'(mem_addr), 64'(exp_ea));
    for (int k = 0; k < lat; k++) begin
      chk(req_ready === 1'b0 && mem_req === 1'b1, "R3 busy hold", 64'(req_ready), 64'h0);
      @(negedge clk);
      chk(mem_addr === exp_ea, "R3 addr stable", 64'(mem_addr), 64'(exp_ea));
    end
    mem_ack = 1'b1; mem_rdata = pte;
    @(posedge clk);
    @(negedge clk);
    mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF;
    if (flt) begin
      exp_status = 32'hC082_0000 | (wr ? 32'h0 : 32'h0004_0000);
      exp_eaddr  = {a[31:12], 12'h0};
    end
    chk(done === 1'b1, "R11 done pulse", 64'(done), 64'h1);
    chk(done_err === flt, wr ? "R5/R4 err flag" : "R4 err flag", 64'(done_err), 64'(flt));
    chk(xlat_addr === exp_pa, "R8 phys addr", 64'(xlat_addr), 64'(exp_pa));
    chk(err_status === exp_status, flt ? "R6 status" : "R8 status kept",
        64'(err_status), 64'(exp_status));
    chk(err_addr === exp_eaddr, flt ? (had_fault ? "R9 overwrite addr" : "R7 fault addr")
        : "R8 addr kept", 64'(err_addr), 64'(exp_eaddr));
    if (flt) had_fault = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && req_ready === 1'b1, "R11 single cycle", 64'(done), 64'h0);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_req === 1'b0, "R1 handshake idle", 64'(req_ready), 64'h1);
    chk(done === 1'b0 && done_err === 1'b0, "R1 done idle", 64'(done), 64'h0);
    chk(err_status === 32'h0 && err_addr === 32'h0, "R1 fault regs", 64'(err_status), 64'h0);
    for (int s = 0; s < 8; s++) begin
      range_sel = 3'(s);
      base = 32'h00AB_C000 + 32'(s) * 32'h0001_1111;
      for (int i = 0; i < 8; i++) begin
        logic [31:0] a;
        logic [23:0] ppn;
        case (i)
          0: a = 32'hFFFF_FFFF;
          1: a = 32'h0000_0000;
          2: a = (32'h1 << (24 + s)) - 32'h1;
          3: a = 32'h1 << (24 + s);
          default: a = 32'(s) * 32'h9E37_79B1 + 32'(i) * 32'h1234_5677;
        endcase
        ppn = 24'(32'(i) * 32'h3579B + 32'(s) * 32'h1F2E3);
        for (int f = 0; f < 4; f++) begin
          for (int w = 0; w < 2; w++) begin
            logic [7:0] fl;
            fl = 8'h81 | (8'(f & 1) << 1) | (8'((f >> 1) & 1) << 2);
            run_req(a ^ (32'(f) << 12), w[0], {ppn ^ 24'(f * 7), fl}, (i + f + w) % 3);
          end
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule